// File: doc/BRIEF.md
# USB Host Root-Port State Controller

This block holds the control logic for the single root port of a USB host. Software drives it through one control/status word. The word holds the port-reset, suspend and resume commands, the enable-change and wakeup flags, the latched device speed and two interrupt mask bits. The port moves through five states: Disconnected, Reset, Enabled, Suspended and Resume. The block asks the PHY to drive a single-ended zero while in Reset, a K state while in Resume, and nothing in any other state.

Sampled D+/D- levels go to a line monitor. The monitor debounces device attachment and infers the speed from the pulled-up line. It also spots a remote-wakeup K state during suspend and a disconnect (a long SE0). Software times the bus reset and the resume window itself: the hardware holds each condition exactly as long as the command bit stays set. In Enabled, a programmable cycle counter emits a frame tick. The tick becomes a start-of-frame pulse for a full-speed device and a keep-alive pulse for a low-speed device.

Top module: `usb_hostport_ctrl`

## Requirements
- R1: After reset, every status word bit reads 0, the line request is idle (0), and no tick or interrupt is raised.
- R2: While no device is connected, a D+/D- level other than SE0 or SE1 that stays unchanged for DEB_CYC cycles sets the connect bit (bit 0). The connect bit is set two cycles after the level stops changing plus DEB_CYC cycles. A shorter pulse is ignored. Both {D+,D-}=10 (full speed) and 01 (low speed) count as attachment.
- R3: Writing 1 to the reset command bit (bit 3) while connected makes the line request SE0 (1). The request stays SE0 for as long as the bit remains set, with no internal time limit.
- R4: Clearing the reset command sets the enable bit (bit 1) and the sticky enable-change flag (bit 2). It also latches the speed into bit 7, where 1 means low speed, taken from the line seen at attachment.
- R5: In Enabled, exactly one frame tick occurs every TICK_CYC cycles. It appears on sof_pulse for a full-speed port and on keepalive_pulse for a low-speed port, never on both.
- R6: Writing 1 to the suspend bit (bit 4) takes effect only while Enabled, where it moves the port to Suspended and stops all ticks. In any other state the write leaves the bit at 0.
- R7: Writing 1 to the resume bit (bit 5) while Suspended makes the line request K (2). Clearing it returns the port to Enabled, clears the suspend bit and restarts ticks.
- R8: While Suspended, a K level that holds for WAKE_CYC cycles sets the wakeup flag (bit 6) and the resume bit in hardware, and the line request becomes K. The K level is {D+,D-}=01 for full speed and 10 for low speed.
- R9: An SE0 that holds for DISC_CYC cycles in Enabled or Suspended returns the port to Disconnected. It clears the connect, enable and suspend bits and sets the enable-change flag.
- R10: Writing 1 to a flag bit (2 or 6) clears it, and writing 0 leaves it unchanged. port_irq equals (bit 2 AND mask bit 8) OR (bit 6 AND mask bit 9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr_en | input | 1 | Write strobe for the control/status word |
| csr_wdata | input | 10 | Write data |
| csr_rdata | output | 10 | Current control/status word |
| line_dp | input | 1 | Sampled D+ level (already synchronised) |
| line_dm | input | 1 | Sampled D- level (already synchronised) |
| phy_line_req | output | 2 | Line request: 0 idle, 1 SE0, 2 K |
| sof_pulse | output | 1 | One-cycle start-of-frame tick (full speed) |
| keepalive_pulse | output | 1 | One-cycle keep-alive tick (low speed) |
| port_irq | output | 1 | Masked port interrupt |

## Verification
A scripted full-speed session runs first. It covers attachment, reset, enable, suspend with a host resume, suspend with a remote wakeup, and disconnect. Each step compares the whole status word, the line request and the interrupt, so a wrong state shows up as a wrong bit. A low-speed session then tests the debounce limit one cycle on either side. It also checks the opposite polarity of attach and K, and it counts keep-alive pulses against frame starts to tell the speed routing apart. Short glitches, a reset held far longer than needed, and commands written in states where they must have no effect separate true level sensing from edge sensing and check that state gating works.

// File: rtl/usbhp_pkg.sv
// Shared types and control/status word layout for the host root-port controller.
package usbhp_pkg;

    typedef enum logic [2:0] {
        PS_DISC    = 3'd0,
        PS_RESET   = 3'd1,
        PS_ENABLED = 3'd2,
        PS_SUSPEND = 3'd3,
        PS_RESUME  = 3'd4
    } port_state_e;

    typedef enum logic [1:0] {
        LREQ_IDLE = 2'd0,
        LREQ_SE0  = 2'd1,
        LREQ_K    = 2'd2
    } line_req_e;

    localparam int unsigned CSR_W   = 10;
    localparam int unsigned B_CONN  = 0;
    localparam int unsigned B_EN    = 1;
    localparam int unsigned B_ENCHG = 2;
    localparam int unsigned B_RST   = 3;
    localparam int unsigned B_SUSP  = 4;
    localparam int unsigned B_RSM   = 5;
    localparam int unsigned B_WAKE  = 6;
    localparam int unsigned B_LOW   = 7;
    localparam int unsigned B_MENCH = 8;
    localparam int unsigned B_MWAKE = 9;

endpackage

// File: rtl/hp_line_mon.sv
// Line monitor: counts how long the sampled D+/D- pair has held one value
// and reports attach, SE0 (disconnect) and K (remote wakeup) levels once
// they have been stable for their thresholds.
// Assumes line_dp/line_dm are already synchronised to clk. The outputs are
// levels; the port FSM decides in which states they matter.
module hp_line_mon #(
    parameter int unsigned DEB_CYC  = 100000,
    parameter int unsigned DISC_CYC = 150,
    parameter int unsigned WAKE_CYC = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_dp,
    input  logic line_dm,
    input  logic low_speed_i,
    output logic attach_o,
    output logic attach_low_o,
    output logic se0_o,
    output logic kstate_o
);

    localparam int unsigned MAX_A   = (DEB_CYC > DISC_CYC) ? DEB_CYC : DISC_CYC;
    localparam int unsigned CNT_MAX = (MAX_A > WAKE_CYC) ? MAX_A : WAKE_CYC;
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);

    logic [1:0]    line_q;
    logic [CW-1:0] stable_cnt;
    logic [1:0]    k_code;

    // Register the line pair and count cycles it has not changed (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q     <= 2'b00;
            stable_cnt <= '0;
        end else begin
            line_q <= {line_dp, line_dm};
            if ({line_dp, line_dm} != line_q)
                stable_cnt <= '0;
            else if (stable_cnt != CW'(CNT_MAX))
                stable_cnt <= stable_cnt + 1'b1;
        end
    end

    // Decode stable levels; K polarity follows the latched port speed.
    always_comb begin
        k_code       = low_speed_i ? 2'b10 : 2'b01;
        attach_o     = ((line_q == 2'b10) || (line_q == 2'b01)) &&
                       (stable_cnt >= CW'(DEB_CYC));
        attach_low_o = (line_q == 2'b01);
        se0_o        = (line_q == 2'b00) && (stable_cnt >= CW'(DISC_CYC));
        kstate_o     = (line_q == k_code) && (stable_cnt >= CW'(WAKE_CYC));
    end

endmodule

// File: rtl/hp_frame_tick.sv
// Frame tick generator: while run_i is high, emits a one-cycle tick every
// TICK_CYC cycles; the counter is held at zero while run_i is low.
// Assumes TICK_CYC >= 2.
module hp_frame_tick #(
    parameter int unsigned TICK_CYC = 60000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);

    localparam int unsigned CW = $clog2(TICK_CYC);

    logic [CW-1:0] cnt;

    // Count cycles in the running state and pulse on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else if (!run_i) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else if (cnt == CW'(TICK_CYC - 1)) begin
            cnt    <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt    <= cnt + 1'b1;
            tick_o <= 1'b0;
        end
    end

endmodule

// File: rtl/hp_port_fsm.sv
// Port state machine and control/status bits. Takes software writes and
// line-monitor levels, sequences Disconnected/Reset/Enabled/Suspended/Resume,
// and keeps the sticky flags. Reset and resume durations are timed by
// software; this logic only follows the command bits.
module hp_port_fsm
    import usbhp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wdata,
    input  logic             attach_i,
    input  logic             attach_low_i,
    input  logic             se0_i,
    input  logic             kstate_i,
    output port_state_e      state_o,
    output logic             conn_o,
    output logic             port_en_o,
    output logic             en_chg_o,
    output logic             rst_bit_o,
    output logic             susp_o,
    output logic             rsm_o,
    output logic             wake_o,
    output logic             low_o,
    output logic             msk_en_o,
    output logic             msk_wk_o
);

    port_state_e state_q, state_d;
    logic        conn_low_q;
    logic        disc_ev, go_disc, wake_ev, reset_done, rsm_done, susp_req;

    // Event decode from current state and monitor levels.
    always_comb begin
        disc_ev    = se0_i && conn_o;
        go_disc    = disc_ev && (state_q == PS_DISC || state_q == PS_ENABLED ||
                                 state_q == PS_SUSPEND);
        wake_ev    = (state_q == PS_SUSPEND) && kstate_i && !disc_ev;
        reset_done = (state_q == PS_RESET) && !rst_bit_o;
        rsm_done   = (state_q == PS_RESUME) && !rsm_o;
        susp_req   = wr_en && wdata[B_SUSP] && (state_q == PS_ENABLED) && !rst_bit_o;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_DISC:    if (conn_o && rst_bit_o && !disc_ev) state_d = PS_RESET;
            PS_RESET:   if (!rst_bit_o) state_d = PS_ENABLED;
            PS_ENABLED: begin
                if (disc_ev)        state_d = PS_DISC;
                else if (rst_bit_o) state_d = PS_RESET;
                else if (susp_o)    state_d = PS_SUSPEND;
            end
            PS_SUSPEND: begin
                if (disc_ev)                state_d = PS_DISC;
                else if (kstate_i || rsm_o) state_d = PS_RESUME;
            end
            PS_RESUME:  if (!rsm_o) state_d = PS_ENABLED;
            default:    state_d = PS_DISC;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_DISC;
        else        state_q <= state_d;
    end

    // Connection, enable and speed bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conn_o     <= 1'b0;
            conn_low_q <= 1'b0;
            port_en_o  <= 1'b0;
            low_o      <= 1'b0;
        end else begin
            if (go_disc) begin
                conn_o <= 1'b0;
            end else if (state_q == PS_DISC && !conn_o && attach_i) begin
                conn_o     <= 1'b1;
                conn_low_q <= attach_low_i;
            end
            if (go_disc)
                port_en_o <= 1'b0;
            else if (reset_done)
                port_en_o <= 1'b1;
            else if (state_q == PS_ENABLED && rst_bit_o)
                port_en_o <= 1'b0;
            if (reset_done)
                low_o <= conn_low_q;
        end
    end

    // Command bits: reset, suspend, resume.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_bit_o <= 1'b0;
            susp_o    <= 1'b0;
            rsm_o     <= 1'b0;
        end else begin
            if (wr_en)
                rst_bit_o <= wdata[B_RST];
            if (go_disc || rsm_done)
                susp_o <= 1'b0;
            else if (susp_req)
                susp_o <= 1'b1;
            if (go_disc)
                rsm_o <= 1'b0;
            else if (wake_ev)
                rsm_o <= 1'b1;
            else if (wr_en && (state_q == PS_SUSPEND || state_q == PS_RESUME))
                rsm_o <= wdata[B_RSM];
        end
    end

    // Sticky write-1-to-clear flags and mask bits; hardware set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_chg_o <= 1'b0;
            wake_o   <= 1'b0;
            msk_en_o <= 1'b0;
            msk_wk_o <= 1'b0;
        end else begin
            if ((go_disc && port_en_o) || reset_done)
                en_chg_o <= 1'b1;
            else if (wr_en && wdata[B_ENCHG])
                en_chg_o <= 1'b0;
            if (wake_ev)
                wake_o <= 1'b1;
            else if (wr_en && wdata[B_WAKE])
                wake_o <= 1'b0;
            if (wr_en) begin
                msk_en_o <= wdata[B_MENCH];
                msk_wk_o <= wdata[B_MWAKE];
            end
        end
    end

    assign state_o = state_q;

    // R4: the enable bit never rises without the enable-change flag.
    a_r4_en_rise_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_en_o) |-> en_chg_o);

    // R6: the suspend bit is only ever held by an enabled port.
    a_r6_susp_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        susp_o |-> port_en_o);

    // R8: a new wakeup flag always comes with the resume bit set.
    a_r8_wake_sets_resume: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> rsm_o);

    // R9: losing the connection clears enable and suspend in the same cycle.
    a_r9_disc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conn_o) |-> (!port_en_o && !susp_o));

endmodule

// File: rtl/usb_hostport_ctrl.sv
// Host root-port controller top: joins the line monitor, the port FSM and
// the frame tick, builds the status word, line request and interrupt.
// Assumes line inputs are synchronised and the PHY acts on phy_line_req.
module usb_hostport_ctrl
    import usbhp_pkg::*;
#(
    parameter int unsigned DEB_CYC  = 100000,
    parameter int unsigned DISC_CYC = 150,
    parameter int unsigned WAKE_CYC = 60,
    parameter int unsigned TICK_CYC = 60000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr_en,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    input  logic             line_dp,
    input  logic             line_dm,
    output logic [1:0]       phy_line_req,
    output logic             sof_pulse,
    output logic             keepalive_pulse,
    output logic             port_irq
);

    port_state_e state;
    logic attach, attach_low, se0, kstate, tick;
    logic conn, port_en, en_chg, rst_bit, susp, rsm, wake, low, msk_en, msk_wk;

    hp_line_mon #(
        .DEB_CYC (DEB_CYC),
        .DISC_CYC(DISC_CYC),
        .WAKE_CYC(WAKE_CYC)
    ) u_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_dp     (line_dp),
        .line_dm     (line_dm),
        .low_speed_i (low),
        .attach_o    (attach),
        .attach_low_o(attach_low),
        .se0_o       (se0),
        .kstate_o    (kstate)
    );

    hp_port_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (csr_wr_en),
        .wdata       (csr_wdata),
        .attach_i    (attach),
        .attach_low_i(attach_low),
        .se0_i       (se0),
        .kstate_i    (kstate),
        .state_o     (state),
        .conn_o      (conn),
        .port_en_o   (port_en),
        .en_chg_o    (en_chg),
        .rst_bit_o   (rst_bit),
        .susp_o      (susp),
        .rsm_o       (rsm),
        .wake_o      (wake),
        .low_o       (low),
        .msk_en_o    (msk_en),
        .msk_wk_o    (msk_wk)
    );

    hp_frame_tick #(
        .TICK_CYC(TICK_CYC)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (state == PS_ENABLED),
        .tick_o(tick)
    );

    // Assemble status word, line request, tick routing and interrupt.
    always_comb begin
        csr_rdata          = '0;
        csr_rdata[B_CONN]  = conn;
        csr_rdata[B_EN]    = port_en;
        csr_rdata[B_ENCHG] = en_chg;
        csr_rdata[B_RST]   = rst_bit;
        csr_rdata[B_SUSP]  = susp;
        csr_rdata[B_RSM]   = rsm;
        csr_rdata[B_WAKE]  = wake;
        csr_rdata[B_LOW]   = low;
        csr_rdata[B_MENCH] = msk_en;
        csr_rdata[B_MWAKE] = msk_wk;
        unique case (state)
            PS_RESET:  phy_line_req = LREQ_SE0;
            PS_RESUME: phy_line_req = LREQ_K;
            default:   phy_line_req = LREQ_IDLE;
        endcase
        sof_pulse       = tick && !low;
        keepalive_pulse = tick && low;
        port_irq        = (en_chg && msk_en) || (wake && msk_wk);
    end

    // R3: SE0 is only requested when the reset command was set.
    a_r3_se0_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_line_req == LREQ_SE0) |-> $past(rst_bit));

    // R5: a tick only follows a cycle in which the port was enabled.
    a_r5_tick_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_pulse || keepalive_pulse) |-> $past(port_en));

    // R5: a tick is never routed to both outputs.
    a_r5_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(sof_pulse && keepalive_pulse));

endmodule

// File: tb/usb_hostport_ctrl_tb.sv
module usb_hostport_ctrl_tb;

    localparam int DEB  = 8;
    localparam int DISC = 6;
    localparam int WAKE = 3;
    localparam int TICK = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [9:0] wdata = '0;
    logic [9:0] rdata;
    logic       dp = 1'b0, dm = 1'b0;
    logic [1:0] req;
    logic       sof, ka, irq;
    int         errors = 0;
    int         checks = 0;
    int         n_sof, n_ka;

    always #2.5 clk = ~clk;

    usb_hostport_ctrl #(
        .DEB_CYC(DEB), .DISC_CYC(DISC), .WAKE_CYC(WAKE), .TICK_CYC(TICK)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .csr_wr_en(wr_en), .csr_wdata(wdata),
        .csr_rdata(rdata), .line_dp(dp), .line_dm(dm), .phy_line_req(req),
        .sof_pulse(sof), .keepalive_pulse(ka), .port_irq(irq)
    );

    // op: 0 = set {dp,dm} from arg[1:0], 1 = write arg; exp = {irq, req, rdata}
    typedef struct packed {
        logic        op;
        logic [9:0]  arg;
        logic [7:0]  wt;
        logic [12:0] exp;
    } vec_t;

    localparam vec_t VEC [0:13] = '{
        '{1'b0, 10'h002, 8'd12, 13'h0001},
        '{1'b1, 10'h300, 8'd2,  13'h0301},
        '{1'b1, 10'h308, 8'd3,  13'h0709},
        '{1'b1, 10'h300, 8'd2,  13'h1307},
        '{1'b1, 10'h304, 8'd2,  13'h0303},
        '{1'b1, 10'h310, 8'd3,  13'h0313},
        '{1'b1, 10'h330, 8'd3,  13'h0B33},
        '{1'b1, 10'h300, 8'd3,  13'h0303},
        '{1'b1, 10'h310, 8'd3,  13'h0313},
        '{1'b0, 10'h001, 8'd6,  13'h1B73},
        '{1'b0, 10'h002, 8'd1,  13'h1B73},
        '{1'b1, 10'h340, 8'd3,  13'h0303},
        '{1'b0, 10'h000, 8'd10, 13'h1304},
        '{1'b1, 10'h304, 8'd2,  13'h0300}
    };

    function automatic string row_req(int i);
        case (i)
            0:       return "R2";
            2:       return "R3";
            3:       return "R4";
            5, 8:    return "R6";
            6, 7:    return "R7";
            9, 10:   return "R8";
            11:      return "R7";
            12:      return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    task automatic wr(logic [9:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_line(logic [1:0] v);
        @(negedge clk);
        {dp, dm} = v;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_ticks(int n);
        n_sof = 0;
        n_ka  = 0;
        repeat (n) begin
            @(negedge clk);
            if (sof) n_sof++;
            if (ka)  n_ka++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", {19'b0, irq, req, rdata}, 32'h0);
        chk("R1", {30'b0, sof, ka}, 32'h0);

        // Scripted full-speed session
        for (int i = 0; i < 14; i++) begin
            if (VEC[i].op) wr(VEC[i].arg);
            else           set_line(VEC[i].arg[1:0]);
            idle(int'(VEC[i].wt));
            chk(row_req(i), {19'b0, irq, req, rdata}, {19'b0, VEC[i].exp});
        end

        // R5: full-speed port gives SOF ticks only, one per TICK cycles
        set_line(2'b10);
        idle(12);
        wr(10'h008);
        idle(3);
        wr(10'h000);
        idle(2);
        count_ticks(10 * TICK);
        chk("R5", n_sof, 10);
        chk("R5", n_ka, 0);
        set_line(2'b00);
        idle(10);
        wr(10'h004);
        idle(2);
        chk("R9", {22'b0, rdata}, 32'h000);

        // R2: short glitch is not an attachment
        set_line(2'b10);
        idle(3);
        set_line(2'b00);
        idle(12);
        chk("R2", {31'b0, rdata[0]}, 0);

        // R2: low-speed attach exactly at the debounce limit
        set_line(2'b01);
        idle(9);
        chk("R2", {31'b0, rdata[0]}, 0);
        idle(1);
        chk("R2", {31'b0, rdata[0]}, 1);

        // R3: SE0 held with no internal timeout
        wr(10'h008);
        idle(2);
        chk("R3", {30'b0, req}, 1);
        idle(50);
        chk("R3", {30'b0, req}, 1);
        wr(10'h000);
        idle(2);
        // R4: low speed latched; R10: flag masked off gives no interrupt
        chk("R4", {22'b0, rdata}, 32'h087);
        chk("R10", {31'b0, irq}, 0);
        wr(10'h100);
        idle(1);
        chk("R10", {31'b0, irq}, 1);
        wr(10'h000);
        idle(1);

        // R5: low-speed port gives keep-alive ticks only
        count_ticks(10 * TICK);
        chk("R5", n_ka, 10);
        chk("R5", n_sof, 0);

        // R6: suspend stops ticks
        wr(10'h010);
        idle(3);
        chk("R6", {22'b0, rdata}, 32'h097);
        count_ticks(3 * TICK);
        chk("R6", n_ka, 0);

        // R7: host resume drives K, clearing returns to Enabled with ticks
        wr(10'h020);
        idle(3);
        chk("R7", {30'b0, req}, 2);
        wr(10'h000);
        idle(3);
        chk("R7", {20'b0, req, rdata}, 32'h087);
        count_ticks(10 * TICK);
        chk("R7", n_ka, 10);

        // R9: disconnect from Enabled on a low-speed port
        set_line(2'b00);
        idle(10);
        chk("R9", {29'b0, rdata[2:0]}, 32'h4);
        wr(10'h004);
        idle(2);
        chk("R10", {31'b0, rdata[2]}, 0);

        // R6: suspend write ignored while disconnected
        wr(10'h010);
        idle(3);
        chk("R6", {31'b0, rdata[4]}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule